// File: doc/BRIEF.md
# Low-Frequency Gap Width Qualifier

This block sits in front of the acknowledge and mute detectors of a contactless tag receiver. Its input is the raw gap envelope from the demodulator. A gap is a high period on that line. When the low-frequency carrier is in use, a high period is accepted as a gap only if it lasts longer than one bit period. Shorter highs are treated as noise and are dropped. This costs a fixed set-up delay of one bit period, so the shortest gap that can be used is one bit period wide. When the high-frequency carrier is in use, the envelope is already clean, so the block passes it through with no width test.

The raw input first goes through a synchronizer of `SYNC_STAGES` flops. A counter then measures how long the synchronized line has stayed high. The counter starts from zero on each high period and stops counting at `CYCLES_PER_BIT+1`, so a long gap cannot wrap it. The qualified output rises once the high period has lasted more than `CYCLES_PER_BIT` cycles. It stays high until the synchronized input is seen low, and it falls in that same cycle. The block has no data stream, so it has no valid/ready handshake: every pin is a plain control level, sampled or driven on each cycle.

Top module: `gap_width_qual`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, `gap_o` is 0 and the internal count is 0.
- R2: In low-frequency mode (`hf_mode_i`=0), if `raw_gap_i` is sampled high on H consecutive rising edges with H ≥ CYCLES_PER_BIT+1, then `gap_o` rises right after edge CYCLES_PER_BIT+2. Edges are counted from the first edge that samples the high, which is edge 1. `gap_o` is then high for H−CYCLES_PER_BIT cycles.
- R3: In low-frequency mode, a high run of CYCLES_PER_BIT samples or fewer never sets `gap_o`.
- R4: Once set, `gap_o` stays high for the whole high run, however long it is. It falls right after the second edge that samples `raw_gap_i` low, which is the delay through two synchronizer stages.
- R5: In high-frequency mode (`hf_mode_i`=1), `gap_o` equals `raw_gap_i` as sampled two edges earlier, for any pulse width, including a width of one cycle. The mode input acts on the output directly.
- R6: The internal high-time count never goes above CYCLES_PER_BIT+1. Once it reaches that value, it holds there for as long as the input stays high.
- R7: Each high period is measured from zero. A low of even one cycle clears the count, so two short highs separated by that low never add up to a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_gap_i | input | 1 | Raw gap envelope, 1 = gap (high period) |
| hf_mode_i | input | 1 | 1 = high-frequency bypass, 0 = low-frequency width qualification |
| gap_o | output | 1 | Qualified gap |

## Verification
Every result is counted in rising edges from the edge that samples the input. In high-frequency mode the output follows two edges later. A fall in low-frequency mode is also due two edges later. A rise in low-frequency mode is due CYCLES_PER_BIT+2 edges after the first high sample. The bench keeps a history of what it drove on each cycle. From that history it computes the expected output for each cycle: the bypass value, or the length of the current high run compared with the threshold. It checks `gap_o` on every falling edge, just before it drives the next input. Every timing is therefore checked at the exact cycle it is due, and none only at some later point.

// File: rtl/gwq_pkg.sv
package gwq_pkg;
  typedef enum logic {
    MODE_LF_QUAL = 1'b0,
    MODE_HF_PASS = 1'b1
  } gwq_mode_e;
endpackage

// File: rtl/gwq_sync.sv
module gwq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

  // R5: the output stage carries the previous stage forward by one edge
  if (STAGES > 1) begin : g_chk
    a_r5_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (chain_q[STAGES-1] == $past(chain_q[STAGES-2])));
  end
endmodule

// File: rtl/gwq_width_counter.sv
module gwq_width_counter #(
  parameter int CYCLES_PER_BIT = 8,
  localparam int SAT = CYCLES_PER_BIT + 1,
  localparam int CW  = $clog2(SAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic qual_o
);
  logic [CW-1:0] cnt_q;
  logic          at_sat;

  assign at_sat = (cnt_q == CW'(SAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!level_i) cnt_q <= '0;
    else if (!at_sat)  cnt_q <= cnt_q + 1'b1;
  end

  // count = completed high cycles before this one; qualify when > one bit
  assign qual_o = level_i && (cnt_q >= CW'(CYCLES_PER_BIT));

  a_r1_cnt_reset: assert property (@(posedge clk) !rst_n |=> (cnt_q == '0));
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SAT));
  a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (at_sat && level_i) |=> (cnt_q == CW'(SAT)));
  a_r7_clear_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    !level_i |=> (cnt_q == '0));
  a_r4_drop_with_level: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qual_o) |-> !level_i);
endmodule

// File: rtl/gwq_out_sel.sv
module gwq_out_sel
  import gwq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  gwq_mode_e mode_i,
  input  logic      level_i,
  input  logic      qual_i,
  output logic      gap_o
);
  always_comb begin
    unique case (mode_i)
      MODE_HF_PASS: gap_o = level_i;
      default:      gap_o = qual_i;
    endcase
  end

  a_r3_lf_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_LF_QUAL && gap_o) |-> level_i);
endmodule

// File: rtl/gap_width_qual.sv
module gap_width_qual
  import gwq_pkg::*;
#(
  parameter int CYCLES_PER_BIT = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_gap_i,
  input  logic hf_mode_i,
  output logic gap_o
);
  logic      lvl;
  logic      qual;
  gwq_mode_e mode;

  assign mode = gwq_mode_e'(hf_mode_i);

  gwq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_gap_i), .q_o(lvl)
  );

  gwq_width_counter #(.CYCLES_PER_BIT(CYCLES_PER_BIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .level_i(lvl), .qual_o(qual)
  );

  gwq_out_sel u_sel (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .level_i(lvl), .qual_i(qual), .gap_o(gap_o)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk) !rst_n |=> !gap_o);
  a_r4_fall_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |-> !gap_o);
endmodule

// File: tb/sim_gap_width_qual.sv
module sim_gap_width_qual;
  localparam int CLK_PERIOD = 10;
  localparam int CPB = 8;
  localparam int HN = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw = 1'b0;
  logic hf = 1'b0;
  logic gap;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit drv_hist [HN];
  string req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gap_width_qual #(.CYCLES_PER_BIT(CPB), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .raw_gap_i(raw), .hf_mode_i(hf), .gap_o(gap)
  );

  // value sampled two edges ago is drv_hist[n-2]; high run length ending there
  function automatic bit expect_gap(input int idx, input bit hf_now);
    int run = 0;
    if (idx < 0) return 1'b0;
    if (hf_now) return drv_hist[idx % HN];
    for (int k = idx; k >= 0 && run <= CPB; k--) begin
      if (drv_hist[k % HN]) run++;
      else break;
    end
    return run >= CPB + 1;
  endfunction

  task automatic check(input bit exp_v);
    checks++;
    if (gap !== exp_v) begin
      errors++;
      $display("FAIL %s cycle %0d: gap_o=%b expected %b", req, n, gap, exp_v);
    end
  endtask

  // called at negedge: check, then drive the next value
  task automatic step(input bit v);
    check(expect_gap(n - 2, hf));
    raw = v;
    drv_hist[n % HN] = v;
    n++;
    @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    for (int i = 0; i < hi; i++) step(1'b1);
    for (int i = 0; i < lo; i++) step(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    req = "R1";
    check(1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0);
    // inputs driven before history start are zero
    pulse(0, 4);

    req = "R3"; pulse(CPB, 6);
    req = "R3"; pulse(CPB - 1, 6);
    req = "R3"; pulse(1, 6);
    req = "R2"; pulse(CPB + 1, 6);
    req = "R2"; pulse(CPB + 3, 6);
    req = "R4"; pulse(CPB * 6, 6);
    req = "R7"; pulse(CPB, 1); pulse(CPB, 6);
    req = "R7"; pulse(CPB - 2, 1); pulse(3, 6);
    req = "R6"; pulse(CPB * 3, 1); pulse(CPB, 6);

    hf = 1'b1;
    req = "R5"; pulse(1, 1); pulse(1, 3); pulse(2, 2); pulse(CPB * 2, 4);
    hf = 1'b0;
    pulse(0, 4);

    // random mix of both modes
    void'($urandom(32'h5eed_1234));
    for (int seg = 0; seg < 300; seg++) begin
      int hi = 1 + ($urandom % (3 * CPB));
      int lo = 1 + ($urandom % 5);
      hf = ($urandom % 4) == 0;
      req = hf ? "R5" : (hi > CPB ? "R2" : "R3");
      pulse(hi, lo);
      pulse(0, 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule